// File: doc/BRIEF.md
# Segmented Word Access Address Splitter

This block takes a logical address given as a 16-bit segment and a 16-bit offset and turns it into the byte-wide bus cycles that one access needs. The physical address of a byte is the segment multiplied by sixteen plus the offset. A byte access always needs exactly one bus cycle. A word access needs two bus cycles: the low byte goes first, then the high byte.

The only difficult case is a word that starts at the last offset of a segment (0xFFFF). A two-bit mode value, captured with the request, decides what happens to the second byte:
- It can wrap to offset zero of the same segment.
- It can continue to the next linear address.
- It can be refused. In that case no bus cycle is issued and a fault is raised.

A separate enable captured with the request decides whether physical bit 20 is passed through or forced to zero.

The requester hands over one request at a time through a valid/ready pair. The bus side sees each byte cycle as a valid signal with an address and a lane bit, and that cycle is held until the bus signals ready. A one-clock done pulse closes every request. For a refused request, the same pulse comes together with the fault flag.

Top module: `seg_word_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_valid`, `done` and `fault` are 0.
- R2: A byte access (`req_word`=0) produces exactly one bus cycle at `seg*16 + off` with `bus_hi`=0. It never faults, whatever the mode or offset.
- R3: A word access at an offset below 0xFFFF produces two cycles. The first is at address P with `bus_hi`=0. The second is at address P+1 with `bus_hi`=1.
- R4: With mode 2'b00, a word at offset 0xFFFF sends its second byte to `seg*16 + 0`, which is offset zero of the same segment.
- R5: With mode 2'b01, a word at offset 0xFFFF sends its second byte to the first byte's address plus one. For example, 0x1000:0xFFFF gives 0x1FFFF and then 0x20000.
- R6: With mode 2'b10, a word at offset 0xFFFF issues no bus cycle. Instead, `fault` and `done` are both 1 for exactly one clock.
- R7: Mode 2'b11 behaves exactly like mode 2'b00.
- R8: When `a20_en` was 0 at acceptance, `bus_addr[20]` is 0 on every cycle of that request. When it was 1, bit 20 carries the full sum.
- R9: A bus cycle keeps `bus_valid`, `bus_addr` and `bus_hi` unchanged until a clock edge at which `bus_ready` is 1. The next cycle or the done pulse follows that edge.
- R10: `done` is 1 for one clock, in the cycle after the last bus cycle completes. The block then returns to idle with `req_ready`=1.
- R11: A request is accepted only while `req_ready` is 1. Segment, offset, size, mode and A20 enable are captured at acceptance. Changing the inputs or raising `req_valid` while busy has no effect on the transfer that is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken on this edge |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset value |
| req_word | input | 1 | 1 = 16-bit word access, 0 = byte |
| req_mode | input | 2 | Boundary mode: 00 wrap, 01 linear, 10 fault, 11 as wrap |
| a20_en | input | 1 | 1 lets physical bit 20 through |
| bus_valid | output | 1 | Byte cycle presented |
| bus_addr | output | 21 | Physical byte address |
| bus_hi | output | 1 | 0 = low byte lane, 1 = high byte lane |
| bus_ready | input | 1 | Bus accepts the presented cycle |
| fault | output | 1 | Refused boundary-crossing word |
| done | output | 1 | One-clock end-of-request pulse |

## Verification
The assertions assume that `bus_ready` is only meaningful while `bus_valid` is high. They also assume that request fields matter only in the cycle where `req_valid` meets `req_ready`. The stimulus drives `bus_ready` randomly whether or not a cycle is pending. It scrambles the request fields, and pokes `req_valid`, right after acceptance while the block is busy. The offsets are biased towards 0xFFFF and nearby values, so that every mode meets the boundary many times. Segments near 0xFFFF, combined with both A20 settings, exercise the 21-bit overflow.

// File: rtl/seg_split_pkg.sv
package seg_split_pkg;

  typedef enum logic [1:0] {
    BMODE_WRAP   = 2'b00,
    BMODE_LINEAR = 2'b01,
    BMODE_FAULT  = 2'b10,
    BMODE_RSVD   = 2'b11
  } bmode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_FIN,
    ST_FAULT
  } xfer_state_t;

endpackage

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
  import seg_split_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = SEG_W + SHIFT + 1
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic             second,
  input  bmode_t           mode,
  input  logic             a20_en,
  output logic [PA_W-1:0]  addr
);

  localparam int EXT_W = PA_W - OFF_W;

  logic [PA_W-1:0]  base;
  logic [PA_W-1:0]  first_pa;
  logic [OFF_W-1:0] off_inc;
  logic [PA_W-1:0]  raw;

  always_comb begin
    base     = {{(PA_W-SEG_W-SHIFT){1'b0}}, seg, {SHIFT{1'b0}}};
    first_pa = base + {{EXT_W{1'b0}}, off};
    off_inc  = off + {{(OFF_W-1){1'b0}}, 1'b1};
    if (!second) begin
      raw = first_pa;
    end else if (mode == BMODE_LINEAR) begin
      raw = first_pa + {{(PA_W-1){1'b0}}, 1'b1};
    end else begin
      raw = base + {{EXT_W{1'b0}}, off_inc};
    end
    addr = a20_en ? raw : {1'b0, raw[PA_W-2:0]};
  end

endmodule

// File: rtl/seg_xfer_ctrl.sv
module seg_xfer_ctrl
  import seg_split_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic fault_hit,
  input  logic word_q,
  input  logic bus_ready,
  output logic accept,
  output logic req_ready,
  output logic bus_valid,
  output logic second,
  output logic fault,
  output logic done
);

  xfer_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = fault_hit ? ST_FAULT : ST_FIRST;
      ST_FIRST:  if (bus_ready) state_d = word_q ? ST_SECOND : ST_FIN;
      ST_SECOND: if (bus_ready) state_d = ST_FIN;
      ST_FIN:    state_d = ST_IDLE;
      ST_FAULT:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    accept    = req_ready && req_valid;
    bus_valid = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    second    = (state_q == ST_SECOND);
    fault     = (state_q == ST_FAULT);
    done      = (state_q == ST_FIN) || (state_q == ST_FAULT);
  end

  // R10: done lasts one clock and is followed by idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R6: a refusal never overlaps a bus cycle and always closes the request
  p_fault_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!bus_valid && done));

  // R3: the high lane only follows a completed low-lane cycle
  p_hi_follows_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(second) |-> $past(bus_valid && bus_ready && !second));

endmodule

// File: rtl/seg_word_splitter.sv
module seg_word_splitter
  import seg_split_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = SEG_W + SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic             req_word,
  input  logic [1:0]       req_mode,
  input  logic             a20_en,
  output logic             bus_valid,
  output logic [PA_W-1:0]  bus_addr,
  output logic             bus_hi,
  input  logic             bus_ready,
  output logic             fault,
  output logic             done
);

  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic             word_q;
  bmode_t           mode_q;
  logic             a20_q;
  logic             accept;
  logic             fault_hit;
  logic             second;

  assign fault_hit = req_word && (&req_off) && (bmode_t'(req_mode) == BMODE_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= '0;
      off_q  <= '0;
      word_q <= 1'b0;
      mode_q <= BMODE_WRAP;
      a20_q  <= 1'b0;
    end else if (accept) begin
      seg_q  <= req_seg;
      off_q  <= req_off;
      word_q <= req_word;
      mode_q <= bmode_t'(req_mode);
      a20_q  <= a20_en;
    end
  end

  seg_xfer_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .fault_hit (fault_hit),
    .word_q    (word_q),
    .bus_ready (bus_ready),
    .accept    (accept),
    .req_ready (req_ready),
    .bus_valid (bus_valid),
    .second    (second),
    .fault     (fault),
    .done      (done)
  );

  seg_addr_calc #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SHIFT),
    .PA_W  (PA_W)
  ) i_calc (
    .seg    (seg_q),
    .off    (off_q),
    .second (second),
    .mode   (mode_q),
    .a20_en (a20_q),
    .addr   (bus_addr)
  );

  assign bus_hi = second;

  // R9: a pending cycle holds until the bus takes it
  p_hold_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_hi)));

  // R8: masked A20 keeps bit 20 clear on every presented cycle
  p_a20_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !a20_q) |-> !bus_addr[PA_W-1]);

  // R2: a byte request never reaches the high lane
  p_byte_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !word_q) |-> !bus_hi);

  // R11: captured fields stay put while busy
  p_capture_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> ($stable(seg_q) && $stable(off_q) && $stable(word_q)));

endmodule

// File: tb/test_seg_word_splitter.sv
`timescale 1ns/1ps
module test_seg_word_splitter;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_seg;
  logic [15:0] req_off;
  logic        req_word;
  logic [1:0]  req_mode;
  logic        a20_en;
  logic        bus_valid;
  logic [20:0] bus_addr;
  logic        bus_hi;
  logic        bus_ready;
  logic        fault;
  logic        done;

  int checks;
  int fails;

  seg_word_splitter i_seg_word_splitter (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_seg (req_seg), .req_off (req_off), .req_word (req_word),
    .req_mode (req_mode), .a20_en (a20_en),
    .bus_valid (bus_valid), .bus_addr (bus_addr), .bus_hi (bus_hi),
    .bus_ready (bus_ready), .fault (fault), .done (done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Expected address of byte k (0 or 1) of a request, from the requirements
  function automatic logic [20:0] exp_addr(input logic [15:0] s, input logic [15:0] o,
                                           input logic [1:0] m, input logic a, input int k);
    logic [20:0] p;
    logic [15:0] o2;
    p = 21'(s) * 21'd16 + 21'(o);
    if (k == 1) begin
      if (m == 2'b01) begin
        p = p + 21'd1;
      end else begin
        o2 = o + 16'd1;
        p  = 21'(s) * 21'd16 + 21'(o2);
      end
    end
    if (!a) p[20] = 1'b0;
    return p;
  endfunction

  task automatic run_req(input logic [15:0] s, input logic [15:0] o, input logic w,
                         input logic [1:0] m, input logic a, input bit poke);
    int n;
    bit f;
    int idx;
    int cyc;
    bit fin;
    bit rdy;
    string tag;
    f   = w && (o == 16'hFFFF) && (m == 2'b10);
    n   = f ? 0 : (w ? 2 : 1);
    tag = f ? "R6" : (!w ? "R2" : (o != 16'hFFFF ? "R3" :
          (m == 2'b01 ? "R5" : (m == 2'b11 ? "R7" : (m == 2'b00 ? "R4" : "R3")))));
    cyc = 0;
    while (!req_ready && cyc < 64) begin @(negedge clk); cyc++; end
    req_valid = 1'b1; req_seg = s; req_off = o; req_word = w; req_mode = m; a20_en = a;
    @(negedge clk);
    // R11: scramble inputs and optionally poke req_valid while busy
    req_valid = poke; req_seg = 16'($urandom); req_off = 16'($urandom);
    req_word = 1'($urandom); req_mode = 2'($urandom); a20_en = 1'($urandom);
    idx = 0; cyc = 0; fin = 0;
    while (!fin && cyc < 64) begin
      if (cyc > 0) req_valid = 1'b0;
      rdy = ($urandom % 10) < 6;
      bus_ready = rdy;
      if (bus_valid) begin
        chk(idx < n, tag, "unexpected bus cycle", 32'(idx), 32'(n));
        if (idx < n) begin
          chk(bus_addr == exp_addr(s, o, m, a, idx), a ? tag : "R8", "bus_addr",
              32'(bus_addr), 32'(exp_addr(s, o, m, a, idx)));
          chk(bus_hi == (idx == 1), "R9", "bus_hi lane", 32'(bus_hi), 32'(idx == 1));
        end
        chk(!fault, "R6", "fault during cycle", 32'(fault), 32'd0);
        if (rdy) idx++;
      end
      if (done) begin
        chk(fault == f, "R6", "fault at done", 32'(fault), 32'(f));
        chk(idx == n, "R10", "cycle count at done", 32'(idx), 32'(n));
        fin = 1;
      end
      @(negedge clk);
      cyc++;
    end
    bus_ready = 1'b0;
    chk(fin, "R10", "done never seen", 32'(fin), 32'd1);
    chk(req_ready && !bus_valid && !done, "R11", "idle after done, poke ignored",
        {29'd0, req_ready, bus_valid, done}, 32'h4);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_seg = '0; req_off = '0; req_word = 1'b0;
    req_mode = '0; a20_en = 1'b0; bus_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_valid && !done && !fault, "R1", "reset outputs",
        {28'd0, req_ready, bus_valid, done, fault}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_valid && !done && !fault, "R1", "after release",
        {28'd0, req_ready, bus_valid, done, fault}, 32'h8);
    run_req(16'h1000, 16'hFFFF, 1'b1, 2'b01, 1'b1, 1'b0); // R5: 1FFFF then 20000
    run_req(16'h1000, 16'hFFFF, 1'b1, 2'b00, 1'b1, 1'b1); // R4: 1FFFF then 10000
    run_req(16'h1000, 16'hFFFF, 1'b1, 2'b11, 1'b1, 1'b0); // R7
    run_req(16'h1000, 16'hFFFF, 1'b1, 2'b10, 1'b1, 1'b1); // R6
    run_req(16'h1000, 16'hFFFF, 1'b0, 2'b10, 1'b1, 1'b0); // R2 byte never faults
    run_req(16'h1234, 16'h0010, 1'b1, 2'b10, 1'b0, 1'b0); // R3
    run_req(16'hFFFF, 16'hFFFF, 1'b0, 2'b00, 1'b0, 1'b0); // R8 masked
    run_req(16'hFFFF, 16'hFFFF, 1'b0, 2'b00, 1'b1, 1'b0); // R8 passed
    run_req(16'hFFFF, 16'h000F, 1'b1, 2'b01, 1'b1, 1'b1); // R3 crosses 0x100000
    run_req(16'hFFFF, 16'hFFFF, 1'b1, 2'b01, 1'b0, 1'b0); // R5 with mask
    for (int i = 0; i < 400; i++) begin
      logic [15:0] o;
      case ($urandom % 4)
        0:       o = 16'hFFFF;
        1:       o = 16'hFFF0 | 16'($urandom % 16);
        default: o = 16'($urandom);
      endcase
      run_req(16'($urandom), o, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule